// File: doc/BRIEF.md
# H-Bridge Mode and Fault Supervisor

This block turns two direction inputs into commands for the two legs of a full bridge. Each leg is commanded high, low or high-impedance. The block also runs a low-power sleep state, which is entered when both direction inputs are low. It watches four protection inputs, gives each one its own recovery rule, and drives an active-low fault flag that a host processor can sample through an open-drain pad.

The four protection inputs behave as follows:

- **Overcurrent.** The raw overcurrent flag must stay high for a programmable number of cycles before it counts. Once it counts, it is latched and stays latched until the next power-on reset.
- **Overtemperature.** This fault stops the bridge only while its flag is present. Operation resumes when the flag clears.
- **Undervoltage.** This fault stops the bridge only while its flag is present. It also clears the internal timers.
- **Current limit.** A current-limit condition that lasts long enough raises the fault flag, but the bridge keeps driving. The fault clears when the condition goes away or when the bridge enters sleep.

Every output is registered. An input change therefore appears at the outputs one clock edge after it is sampled. Both timers are measured in clock cycles and set by parameters.

Top module: `hbSupervisor`

## Requirements
- R1: Leg commands are encoded as 2'b00 = high-impedance, 2'b01 = driven low, 2'b10 = driven high. While no stopping fault is present, the outputs follow the direction inputs one edge after they are sampled:
  - dirA=1, dirB=0 gives legA high and legB low.
  - dirA=0, dirB=1 gives legA low and legB high.
  - dirA=1, dirB=1 gives both legs high.
- R2: When dirA=0 and dirB=0, the bridge sleeps: both legs are high-impedance and bridgeEn is 0. bridgeEn is 1 in the three driving states when no stopping fault is present.
- R3: A stopping fault is a latched overcurrent, overTemp=1 or underVolt=1. Any stopping fault forces both legs to high-impedance and sets bridgeEn to 0. faultN is 0 (pulled low) while any fault is present. In reset faultN is 1 (released).
- R4: The overcurrent latch sets after ocpRaw has been sampled high on OCP_CYC consecutive edges. The legs go high-impedance on the following edge. A run one sample shorter has no effect.
- R5: A latched overcurrent holds through all of the following: ocpRaw falling, overtemperature, undervoltage, sleep and any direction change. It clears only on the power-on reset rstN.
- R6: The overtemperature fault recovers by itself. One edge after overTemp is sampled low, driving and faultN=1 return.
- R7: Undervoltage recovers by itself, in the same way as overtemperature. While underVolt is high, both deglitch timers are held at zero. An overcurrent run that spans undervoltage therefore never latches, and a current-limit run restarts after undervoltage ends.
- R8: The current-limit fault appears when limActive has been sampled high on LIM_CYC consecutive edges. faultN goes low one edge later, and the legs keep driving. faultN returns to 1 on the second edge after limActive is sampled low.
- R9: Sleep clears the current-limit fault and its timer. Leaving sleep never pulls faultN low by itself, even while limActive stays high.
- R10: When sleep is requested on the same edge that the current-limit timer would expire, no current-limit fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| dirA | input | 1 | Direction input for leg A |
| dirB | input | 1 | Direction input for leg B |
| ocpRaw | input | 1 | Raw per-switch overcurrent flag |
| overTemp | input | 1 | Die overtemperature flag |
| underVolt | input | 1 | Supply undervoltage flag |
| limActive | input | 1 | Current regulation is active |
| legA | output | 2 | Leg A command (00 Z, 01 low, 10 high) |
| legB | output | 2 | Leg B command (00 Z, 01 low, 10 high) |
| bridgeEn | output | 1 | Bridge switches enabled |
| faultN | output | 1 | Fault flag, 0 = pull pad low |

## Verification
Two pairs of events can land on the same clock edge.

- **Undervoltage and the overcurrent trip.** The bench raises underVolt exactly on the edge that would complete the overcurrent deglitch run. It then checks that the bridge comes back driving and that faultN is released once both flags drop, which shows that no latch formed.
- **Sleep and the current-limit expiry.** The bench requests sleep on the edge where the current-limit timer would expire. It then checks that faultN stays released both in sleep and after sleep exits.

// File: rtl/hbSupPkg.sv
package hbSupPkg;

  typedef enum logic [1:0] {
    LEG_Z  = 2'b00,
    LEG_LO = 2'b01,
    LEG_HI = 2'b10
  } legCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic forceOff;    // a stopping fault is present
    logic raiseFault;  // any fault, stopping or not
  } supStrobe_t;

endpackage

// File: rtl/hbSupCtrl.sv
module hbSupCtrl
  import hbSupPkg::*;
#(
  parameter int OCP_CYC = 250,
  parameter int LIM_CYC = 34_375_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dirA,
  input  logic       dirB,
  input  logic       ocpRaw,
  input  logic       overTemp,
  input  logic       underVolt,
  input  logic       limActive,
  output supStrobe_t strobe
);

  localparam int OW = (OCP_CYC > 2) ? $clog2(OCP_CYC) : 1;
  localparam int LW = (LIM_CYC > 2) ? $clog2(LIM_CYC) : 1;
  localparam logic [OW-1:0] OCP_LAST = OW'(OCP_CYC - 1);
  localparam logic [LW-1:0] LIM_LAST = LW'(LIM_CYC - 1);

  logic [OW-1:0] ocpCnt;
  logic [LW-1:0] limCnt;
  logic ocpLatch;
  logic limFlag;
  logic sleepReq;
  logic ocpRun;
  logic limRun;
  logic ocpTrip;

  assign sleepReq = !dirA && !dirB;
  // undervoltage resets the internal timers, so it gates both runs
  assign ocpRun   = ocpRaw && !underVolt;
  assign limRun   = limActive && !underVolt && !sleepReq;
  assign ocpTrip  = ocpRun && (ocpCnt == OCP_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocpCnt <= '0;
    end else if (!ocpRun) begin
      ocpCnt <= '0;
    end else if (ocpCnt != OCP_LAST) begin
      ocpCnt <= ocpCnt + 1'b1;
    end
  end

  // sticky until power-on reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ocpLatch <= 1'b0;
    else if (ocpTrip) ocpLatch <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limCnt <= '0;
    end else if (!limRun) begin
      limCnt <= '0;
    end else if (limCnt != LIM_LAST) begin
      limCnt <= limCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) limFlag <= 1'b0;
    else limFlag <= limRun && (limFlag || (limCnt == LIM_LAST));
  end

  always_comb begin
    strobe.forceOff   = underVolt || ocpLatch || overTemp;
    strobe.raiseFault = underVolt || ocpLatch || overTemp || limFlag;
  end

  // R5: the overcurrent latch never drops before reset
  a_r5_ocp_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ocpLatch |=> ocpLatch);

  // R7: undervoltage leaves both timers and the limit flag cleared
  a_r7_uv_clears_timers: assert property (@(posedge clk) disable iff (!rstN)
    underVolt |=> (ocpCnt == '0 && limCnt == '0 && !limFlag));

  // R7: no overcurrent latch can form on an undervoltage edge
  a_r7_uv_blocks_trip: assert property (@(posedge clk) disable iff (!rstN)
    (underVolt && !ocpLatch) |=> !ocpLatch);

  // R9: sleep clears the current-limit fault
  a_r9_sleep_clears_lim: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |=> !limFlag);

endmodule

// File: rtl/hbSupPath.sv
module hbSupPath
  import hbSupPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dirA,
  input  logic       dirB,
  input  supStrobe_t strobe,
  output logic [1:0] legA,
  output logic [1:0] legB,
  output logic       bridgeEn,
  output logic       faultN
);

  legCmd_e nextA;
  legCmd_e nextB;
  logic    nextEn;

  always_comb begin
    nextA  = LEG_Z;
    nextB  = LEG_Z;
    nextEn = 1'b0;
    if (!strobe.forceOff) begin
      unique case ({dirA, dirB})
        2'b10: begin nextA = LEG_HI; nextB = LEG_LO; nextEn = 1'b1; end
        2'b01: begin nextA = LEG_LO; nextB = LEG_HI; nextEn = 1'b1; end
        2'b11: begin nextA = LEG_HI; nextB = LEG_HI; nextEn = 1'b1; end
        default: begin nextA = LEG_Z; nextB = LEG_Z; nextEn = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      legA     <= LEG_Z;
      legB     <= LEG_Z;
      bridgeEn <= 1'b0;
      faultN   <= 1'b1;
    end else begin
      legA     <= nextA;
      legB     <= nextB;
      bridgeEn <= nextEn;
      faultN   <= !strobe.raiseFault;
    end
  end

  // R3: a stopping fault floats both legs
  a_r3_off_floats: assert property (@(posedge clk) disable iff (!rstN)
    strobe.forceOff |=> (legA == LEG_Z && legB == LEG_Z && !bridgeEn));

  // R1: brake drives both legs high
  a_r1_brake_high: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.forceOff && dirA && dirB) |=> (legA == LEG_HI && legB == LEG_HI));

  // R2: sleep floats both legs
  a_r2_sleep_floats: assert property (@(posedge clk) disable iff (!rstN)
    (!dirA && !dirB) |=> (legA == LEG_Z && legB == LEG_Z && !bridgeEn));

  // R3: any fault pulls the flag low
  a_r3_flag_low: assert property (@(posedge clk) disable iff (!rstN)
    strobe.raiseFault |=> !faultN);

endmodule

// File: rtl/hbSupervisor.sv
module hbSupervisor
  import hbSupPkg::*;
#(
  parameter int OCP_CYC = 250,
  parameter int LIM_CYC = 34_375_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dirA,
  input  logic       dirB,
  input  logic       ocpRaw,
  input  logic       overTemp,
  input  logic       underVolt,
  input  logic       limActive,
  output logic [1:0] legA,
  output logic [1:0] legB,
  output logic       bridgeEn,
  output logic       faultN
);

  supStrobe_t strobe;

  hbSupCtrl #(.OCP_CYC(OCP_CYC), .LIM_CYC(LIM_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .dirA(dirA), .dirB(dirB),
    .ocpRaw(ocpRaw), .overTemp(overTemp), .underVolt(underVolt),
    .limActive(limActive), .strobe(strobe)
  );

  hbSupPath uPath (
    .clk(clk), .rstN(rstN), .dirA(dirA), .dirB(dirB), .strobe(strobe),
    .legA(legA), .legB(legB), .bridgeEn(bridgeEn), .faultN(faultN)
  );

endmodule

// File: tb/sim_hbSupervisor.sv
`timescale 1ns/1ps
module sim_hbSupervisor;

  localparam int OCP = 8;
  localparam int LIM = 40;
  localparam logic [1:0] Z = 2'b00, LO = 2'b01, HI = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirA = 1'b0, dirB = 1'b0;
  logic ocpRaw = 1'b0, overTemp = 1'b0, underVolt = 1'b0, limActive = 1'b0;
  logic [1:0] legA, legB;
  logic bridgeEn, faultN;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hbSupervisor #(.OCP_CYC(OCP), .LIM_CYC(LIM)) u0 (
    .clk(clk), .rstN(rstN), .dirA(dirA), .dirB(dirB), .ocpRaw(ocpRaw),
    .overTemp(overTemp), .underVolt(underVolt), .limActive(limActive),
    .legA(legA), .legB(legB), .bridgeEn(bridgeEn), .faultN(faultN)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect4(input string req, input logic [1:0] eA, input logic [1:0] eB,
                         input logic eEn, input logic eF);
    checks++;
    if (legA !== eA || legB !== eB || bridgeEn !== eEn || faultN !== eF) begin
      failures++;
      $display("FAIL %s actual legA=%b legB=%b en=%b faultN=%b expected legA=%b legB=%b en=%b faultN=%b",
               req, legA, legB, bridgeEn, faultN, eA, eB, eEn, eF);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step(2);
    expect4("R3 reset state", Z, Z, 1'b0, 1'b1);
    rstN = 1'b1;
  endtask

  task automatic testDecode();
    dirA = 1; dirB = 0; step(1); expect4("R1 forward", HI, LO, 1'b1, 1'b1);
    dirA = 0; dirB = 1; step(1); expect4("R1 reverse", LO, HI, 1'b1, 1'b1);
    dirA = 1; dirB = 1; step(1); expect4("R1 brake", HI, HI, 1'b1, 1'b1);
    dirA = 0; dirB = 0; step(1); expect4("R2 sleep", Z, Z, 1'b0, 1'b1);
    dirA = 1; dirB = 0; step(1); expect4("R2 wake forward", HI, LO, 1'b1, 1'b1);
  endtask

  task automatic testOcp();
    ocpRaw = 1; step(OCP - 1); ocpRaw = 0; step(2);
    expect4("R4 short overcurrent ignored", HI, LO, 1'b1, 1'b1);
    ocpRaw = 1; step(OCP);
    expect4("R4 latch edge, outputs not yet off", HI, LO, 1'b1, 1'b1);
    step(1);
    expect4("R4 overcurrent trips", Z, Z, 1'b0, 1'b0);
    ocpRaw = 0; step(3);
    expect4("R5 held after raw drops", Z, Z, 1'b0, 1'b0);
    overTemp = 1; step(1); overTemp = 0; underVolt = 1; step(1); underVolt = 0;
    dirA = 0; dirB = 0; step(2); dirA = 0; dirB = 1; step(2);
    expect4("R5 held through faults and sleep", Z, Z, 1'b0, 1'b0);
    dirA = 1; dirB = 0;
    doReset(); step(1);
    expect4("R5 cleared by power-on reset", HI, LO, 1'b1, 1'b1);
  endtask

  task automatic testThermal();
    overTemp = 1; step(1);
    expect4("R6 overtemp stops bridge", Z, Z, 1'b0, 1'b0);
    overTemp = 0; step(1);
    expect4("R6 overtemp recovers", HI, LO, 1'b1, 1'b1);
  endtask

  task automatic testUv();
    underVolt = 1; step(1);
    expect4("R7 undervoltage stops bridge", Z, Z, 1'b0, 1'b0);
    underVolt = 0; step(1);
    expect4("R7 undervoltage recovers", HI, LO, 1'b1, 1'b1);
    // undervoltage arrives on the edge that would complete the deglitch run
    ocpRaw = 1; step(OCP - 1); underVolt = 1; step(1);
    expect4("R7 undervoltage wins same edge", Z, Z, 1'b0, 1'b0);
    ocpRaw = 0; underVolt = 0; step(1);
    expect4("R7 no overcurrent latch formed", HI, LO, 1'b1, 1'b1);
    // current-limit timer restarts after undervoltage
    limActive = 1; step(LIM - 2); underVolt = 1; step(1); underVolt = 0; step(LIM);
    expect4("R7 limit timer restarted", HI, LO, 1'b1, 1'b1);
    step(1);
    expect4("R8 fault after full restarted run", HI, LO, 1'b1, 1'b0);
    limActive = 0; step(2);
  endtask

  task automatic testLimit();
    limActive = 1; step(LIM);
    expect4("R8 flag edge, faultN not yet low", HI, LO, 1'b1, 1'b1);
    step(1);
    expect4("R8 limit fault keeps driving", HI, LO, 1'b1, 1'b0);
    limActive = 0; step(1);
    expect4("R8 one edge after drop still low", HI, LO, 1'b1, 1'b0);
    step(1);
    expect4("R8 limit fault self-clears", HI, LO, 1'b1, 1'b1);
    limActive = 1; step(LIM + 1);
    expect4("R8 limit fault again", HI, LO, 1'b1, 1'b0);
    dirA = 0; dirB = 0; step(2);
    expect4("R9 sleep clears limit fault", Z, Z, 1'b0, 1'b1);
    dirA = 1; dirB = 0; step(1);
    expect4("R9 no fault pulse on sleep exit", HI, LO, 1'b1, 1'b1);
    step(LIM - 2);
    expect4("R9 timer restarted from zero", HI, LO, 1'b1, 1'b1);
    dirA = 0; dirB = 0; step(2);
    expect4("R10 sleep on expiry edge", Z, Z, 1'b0, 1'b1);
    dirA = 1; dirB = 0; step(1);
    expect4("R10 no fault after wake", HI, LO, 1'b1, 1'b1);
    limActive = 0; step(2);
  endtask

  initial begin
    step(1);
    doReset();
    testDecode();
    testOcp();
    testThermal();
    testUv();
    testLimit();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule